// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter built from identical 4-bit stages. Each stage has a parallel preset, two count-enable inputs and a carry output. The top module chains `STAGES` stages into a counter `STAGES*4` bits wide. All stages share one clock, one clear, one load and the P enable. The T enable of the first stage comes from the port. The T enable of every later stage comes from the carry of the stage below it, and no extra gating sits between stages.

A parameter chooses the clear style. With `SYNC_CLEAR = 1` the active-low clear takes effect at the next rising edge. This lets a decode of a chosen count, fed back to the clear input, shorten the cycle. With `SYNC_CLEAR = 0` the clear forces the state to zero as soon as it goes low.

Top module: `cascade_counter`

## Requirements
- R1: Every state bit of every stage updates on the same rising clock edge. A rollover across stage boundaries, such as 0x0FF to 0x100, completes in one edge.
- R2: The count advances by exactly one on a rising edge only when `en_p` and `en_t` are both high, and load and clear are inactive.
- R3: When `ld_n` is low and clear is inactive, `din` is copied into the count at the next rising edge, whatever the enable levels are.
- R4: With `SYNC_CLEAR = 0`, a low `clr_n` forces the count to zero at once, before any clock edge. The count stays zero while `clr_n` is low, whatever the clock, load and enables are.
- R5: With `SYNC_CLEAR = 1`, a low `clr_n` forces the count to zero at the next rising edge and not before. Feeding back "count is 9" into `clr_n` on one stage gives a repeating 0 to 9 sequence.
- R6: `carry` is high only when `en_t` is high and the count is all ones. It does not depend on `en_p`.
- R7: The chained counter behaves as one integer counter modulo 2^(4*STAGES) under any mix of P, load and clear stimulus.
- R8: Counting from the maximum value (all ones) gives zero on the next enabled edge.
- R9: With clear and load inactive and `en_p` and `en_t` not both high, the count holds its value.
- R10: Clear has priority over load, and load has priority over counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous according to SYNC_CLEAR |
| ld_n | input | 1 | Active-low synchronous parallel load |
| din | input | 4*STAGES | Preset value |
| en_p | input | 1 | Count enable P, shared by all stages |
| en_t | input | 1 | Count enable T of the first stage; also gates the carry |
| q | output | 4*STAGES | Count value |
| carry | output | 1 | Carry from the last stage: en_t high and count all ones |

## Verification
The bench targets a carry that crosses several stages in one edge. A design that rippled between stages, or gated a later stage with the wrong enable, would show 0x000 or 0x1FF instead of 0x100. It checks that `carry` follows T and ignores P, that the maximum wraps to zero, and that clear beats load. A wrong priority would leave the loaded value in place. A 0 to 9 loop fed by a count-9 decode tells a synchronous clear that acts too early apart from a correct one, because the early clear makes a 0 to 8 loop. An asynchronous instance is checked for zero between edges. A long random run compares the 12-bit chain against an integer counter model.

// File: rtl/cascade_counter.sv
module count_stage #(
  parameter int WIDTH      = 4,
  parameter bit SYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] d,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             rco
);
  logic [WIDTH-1:0] nxt;

  assign nxt = !ld_n ? d : (en_p && en_t) ? q + 1'b1 : q;
  assign rco = en_t && (&q);

  generate
    if (SYNC_CLEAR) begin : g_sync
      always_ff @(posedge clk)
        q <= !clr_n ? '0 : nxt;
    end else begin : g_async
      always_ff @(posedge clk or negedge clr_n)
        if (!clr_n) q <= '0;
        else        q <= nxt;
    end
  endgenerate
endmodule

module cascade_counter #(
  parameter int STAGES     = 3,
  parameter int STAGE_W    = 4,
  parameter bit SYNC_CLEAR = 1'b1,
  localparam int W         = STAGES * STAGE_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic [W-1:0] din,
  input  logic         en_p,
  input  logic         en_t,
  output logic [W-1:0] q,
  output logic         carry
);
  logic [STAGES:0] t_chain;

  assign t_chain[0] = en_t;
  assign carry      = t_chain[STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      count_stage #(.WIDTH(STAGE_W), .SYNC_CLEAR(SYNC_CLEAR)) u_stage (
        .clk  (clk),
        .clr_n(clr_n),
        .ld_n (ld_n),
        .d    (din[i*STAGE_W +: STAGE_W]),
        .en_p (en_p),
        .en_t (t_chain[i]),
        .q    (q[i*STAGE_W +: STAGE_W]),
        .rco  (t_chain[i+1])
      );
    end
  endgenerate
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int STAGES     = 3,
  parameter int STAGE_W    = 4,
  parameter bit SYNC_CLEAR = 1'b1,
  localparam int W         = STAGES * STAGE_W
) (
  input logic         clk,
  input logic         clr_n,
  input logic         ld_n,
  input logic [W-1:0] din,
  input logic         en_p,
  input logic         en_t,
  input logic [W-1:0] q,
  input logic         carry
);
  logic [1:0] armed = 2'b00;
  always_ff @(posedge clk) armed <= {armed[0], 1'b1};
  wire on = armed[1];

  // R2 R7 R8: one increment per enabled edge, wrapping at the top
  a_r2_count: assert property (@(posedge clk) disable iff (!on)
    (clr_n && ld_n && en_p && en_t) |=>
      ((q == $past(q) + 1'b1) || (!SYNC_CLEAR && !clr_n)));

  // R3 R10: load beats the enables
  a_r3_load: assert property (@(posedge clk) disable iff (!on)
    (clr_n && !ld_n) |=> ((q == $past(din)) || (!SYNC_CLEAR && !clr_n)));

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!on)
    (clr_n && ld_n && !(en_p && en_t)) |=>
      ($stable(q) || (!SYNC_CLEAR && !clr_n)));

  // R6
  a_r6_carry: assert property (@(posedge clk) disable iff (!on)
    carry == (en_t && (&q)));

  generate
    if (SYNC_CLEAR) begin : g_sc
      // R5 R10
      a_r5_sync_clear: assert property (@(posedge clk) disable iff (!on)
        !clr_n |=> (q == '0));
    end else begin : g_ac
      // R4
      a_r4_async_clear: assert property (@(posedge clk) disable iff (!on)
        !clr_n |-> (q == '0));
    end
  endgenerate
endmodule

bind cascade_counter cascade_counter_chk #(
  .STAGES(STAGES), .STAGE_W(STAGE_W), .SYNC_CLEAR(SYNC_CLEAR)
) u_chk (
  .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
  .en_p(en_p), .en_t(en_t), .q(q), .carry(carry)
);

// File: tb/sim_cascade_counter.sv
`timescale 1ns/1ps
module sim_cascade_counter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // 12-bit synchronous-clear chain
  logic        clr_n = 1'b0, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [11:0] din = '0;
  logic [11:0] q;
  logic        carry;

  cascade_counter #(.STAGES(3), .STAGE_W(4), .SYNC_CLEAR(1'b1)) u0 (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q), .carry(carry));

  // single stage with count-9 decode on its synchronous clear
  logic       ext1 = 1'b0;
  logic [3:0] q1;
  logic       c1;
  wire        clr1 = ext1 & ~(q1 == 4'd9);

  cascade_counter #(.STAGES(1), .STAGE_W(4), .SYNC_CLEAR(1'b1)) u1 (
    .clk(clk), .clr_n(clr1), .ld_n(1'b1), .din(4'd0),
    .en_p(1'b1), .en_t(1'b1), .q(q1), .carry(c1));

  // single stage with asynchronous clear
  logic       clr2 = 1'b1, ld2 = 1'b1, p2 = 1'b0, t2 = 1'b0;
  logic [3:0] d2 = '0;
  logic [3:0] q2;
  logic       c2;

  cascade_counter #(.STAGES(1), .STAGE_W(4), .SYNC_CLEAR(1'b0)) u2 (
    .clk(clk), .clr_n(clr2), .ld_n(ld2), .din(d2),
    .en_p(p2), .en_t(t2), .q(q2), .carry(c2));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int ref_q;
    // R5 reset through synchronous clear
    step();
    chk("R5 clear at edge", q, 0);
    chk("R6 carry low at zero", carry, 0);

    // R3 load with enables low
    clr_n = 1; ld_n = 0; din = 12'h0FE; en_p = 0; en_t = 0;
    step();
    chk("R3 load ignores enables", q, 12'h0FE);

    // R2 R1 count across stage boundary in one edge
    ld_n = 1; en_p = 1; en_t = 1;
    step();
    chk("R2 count by one", q, 12'h0FF);
    chk("R6 carry low below max", carry, 0);
    step();
    chk("R1 multi-stage rollover", q, 12'h100);

    // R9 hold
    en_p = 0;
    step(); step();
    chk("R9 hold with P low", q, 12'h100);
    en_p = 1; en_t = 0;
    step();
    chk("R9 hold with T low", q, 12'h100);

    // R6 carry at max
    ld_n = 0; din = 12'hFFF;
    step();
    ld_n = 1; en_t = 1; en_p = 0;
    #0.5;
    chk("R6 carry ignores P", carry, 1);
    en_t = 0;
    #0.5;
    chk("R6 carry gated by T", carry, 0);
    en_t = 1; en_p = 1;
    #0.5;
    chk("R6 carry with P and T", carry, 1);

    // R8 wrap
    step();
    chk("R8 wrap to zero", q, 0);
    chk("R6 carry drops after wrap", carry, 0);

    // R10 clear over load
    clr_n = 0; ld_n = 0; din = 12'h555;
    step();
    chk("R10 clear beats load", q, 0);

    // R10 load over count
    clr_n = 1; ld_n = 0; din = 12'h123; en_p = 1; en_t = 1;
    step();
    chk("R10 load beats count", q, 12'h123);

    // R5 synchronous clear waits for edge
    ld_n = 1; en_p = 0; clr_n = 0;
    #1;
    chk("R5 no clear before edge", q, 12'h123);
    step();
    chk("R5 clear after edge", q, 0);
    clr_n = 1;

    // R7 random run against integer model
    ref_q = 0;
    for (int i = 0; i < 4000; i++) begin
      clr_n = ($urandom % 50) != 0;
      ld_n  = ($urandom % 40) != 0;
      din   = ($urandom % 2) ? (12'hFF0 | 12'($urandom % 16)) : 12'($urandom);
      en_p  = ($urandom % 4) != 0;
      en_t  = ($urandom % 8) != 0;
      #0.5;
      chk("R7 R6 chain carry", carry, (en_t && ref_q == 4095) ? 1 : 0);
      if (!clr_n)             ref_q = 0;
      else if (!ld_n)         ref_q = din;
      else if (en_p && en_t)  ref_q = (ref_q + 1) % 4096;
      step();
      chk("R7 chain count", q, ref_q);
    end

    // R5 count-9 decode gives 0..9 cycle
    step();
    chk("R5 decode stage cleared", q1, 0);
    ext1 = 1;
    for (int i = 1; i <= 30; i++) begin
      step();
      chk("R5 mod-10 sequence", q1, i % 10);
    end

    // R4 asynchronous clear
    ld2 = 0; d2 = 4'd7;
    step();
    chk("R3 async stage load", q2, 7);
    ld2 = 1; clr2 = 0;
    #0.5;
    chk("R4 clear before edge", q2, 0);
    ld2 = 0; d2 = 4'hA; p2 = 1; t2 = 1;
    step();
    chk("R4 clear holds over load and enables", q2, 0);
    clr2 = 1;
    step();
    chk("R3 load after clear release", q2, 4'hA);
    ld2 = 1;
    step();
    chk("R2 async stage counts", q2, 4'hB);

    finish_run();
  end
endmodule